// File: doc/BRIEF.md
# Configurable PWM Channel Generator

One pulse-width modulation channel. A counter advances on a selectable time base and is compared with an active duty value. The result is a comparator waveform, which is used in three ways. It drives a complementary high/low output pair. It drives a one-cycle counter-event pulse. It drives a trigger line for a timer. A mode word selects the following:

- left-aligned or center-aligned counting
- the level each period starts at
- the level held while the channel is off
- where buffered period and duty writes take effect
- where counter events fire
- the source of the timer trigger
- the behaviour of the complementary pair

The period and duty writes from software land in shadow registers. The shadows are copied into the active registers only at the selected update point, so a running waveform never shows a torn period. External clocks A and B enter as single-cycle tick strobes that are synchronous to the peripheral clock. A write-protect flag freezes the mode word.

Top module: `pwm_chan`

## Requirements
- R1: After reset the mode word is all zero. With the channel off, `ocOut`=0, `pairHi`=0, `pairLo`=1, `trigOut`=0 and `evtOut`=0.
- R2: With left alignment (modeData bit 4 = 0) and an active period P≥1, the counter starts at 0 on enable and steps 0..P-1 on each tick, then wraps. `ocOut` equals the start level while the count is below the active duty, and the inverse from the duty value onward.
- R3: With center alignment (bit 4 = 1) the counter steps up 0..P and then back down to 0, so one period spans 2P ticks. `ocOut` follows the same count-below-duty rule, which makes the pulse symmetric about the top.
- R4: Start-level bit 5 sets the level `ocOut` holds at the start of each period: 0 low, 1 high.
- R5: While `chanEn` is 0 the counter is held at 0, shadow period and duty pass straight to the active registers, and `ocOut` holds bit 5 XOR idle-invert bit 6.
- R6: In left mode, and in center mode with update-select bit 7 = 0, a shadow write takes effect only at the next period end.
- R7: In center mode with bit 7 = 1, a shadow write takes effect at the next half-period point (top of count) or period end, whichever comes first.
- R8: `evtOut` pulses for one cycle, in the cycle the count returns to 0 at a period end. In center mode with event-select bit 8 = 1 it also pulses when the count reaches the top. In left mode bit 8 has no effect.
- R9: Prescaler field bits 3:0 with codes 0..10 advance the counter once every 2^code peripheral clocks.
- R10: Code 11 advances on `extTickA` pulses only, and code 12 on `extTickB` only. Codes 13..15 never advance the counter.
- R11: `trigOut` equals `ocOut` when trigger-select bit 9 = 0, and equals `evtOut` when it is 1.
- R12: With pair-enable bit 10 = 1, `pairHi` = `ocOut` XOR bit 11 and `pairLo` = NOT `ocOut` XOR bit 12. With bit 10 = 0, `pairHi` = `ocOut` and `pairLo` = NOT `ocOut`, and bits 11 and 12 are ignored.
- R13: A mode write (`modeWr`) issued while `wrProtect` is 1 leaves the mode word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| extTickA | input | 1 | External clock A tick strobe |
| extTickB | input | 1 | External clock B tick strobe |
| chanEn | input | 1 | Channel enable |
| wrProtect | input | 1 | Mode write protect status |
| modeWr | input | 1 | Mode word write strobe |
| modeData | input | 13 | Mode word write data |
| perWr | input | 1 | Period shadow write strobe |
| perData | input | CNT_W | Period write data |
| dutyWr | input | 1 | Duty shadow write strobe |
| dutyData | input | CNT_W | Duty write data |
| ocOut | output | 1 | Comparator waveform |
| pairHi | output | 1 | Complementary pair high side |
| pairLo | output | 1 | Complementary pair low side |
| evtOut | output | 1 | Channel counter-event pulse |
| trigOut | output | 1 | Timer trigger |

## Verification
The bench watches where a duty change lands. A design that loads shadows immediately, or at the wrong turn point, shows the new pulse width one half or one full period early or late. A design that ignores the update-select bit loads at the same point in both center-mode runs. Center runs are compared sample by sample through the top turnaround. An off-by-one top count or a missing half-period event therefore shifts the whole waveform. Separate directed runs cover:
- the divide-by-four spacing of events
- ticks on the unselected external clock, which must be ignored
- reserved prescaler codes, which must keep the counter still
- a mode write under protection, which must leave the idle level unchanged

// File: rtl/pwm_chan_pkg.sv
`timescale 1ns/1ps
package pwm_chan_pkg;

  localparam int MODE_W = 13;

  // Mode word layout, LSB at the prescaler field
  typedef struct packed {
    logic       invLo;       // 12
    logic       invHi;       // 11
    logic       compEn;      // 10
    logic       trigEvt;     // 9
    logic       evtHalf;     // 8
    logic       updHalf;     // 7
    logic       idleInvert;  // 6
    logic       startHigh;   // 5
    logic       alignCenter; // 4
    logic [3:0] prescSel;    // 3:0
  } modeT;

  typedef struct packed {
    logic startHigh;
    logic idleInvert;
    logic compEn;
    logic invHi;
    logic invLo;
    logic trigEvt;
  } outCfgT;

  // Control to datapath strobes
  typedef struct packed {
    logic run;
    logic leftWrap;
    logic stepUp;
    logic stepDown;
    logic turnDown;
    logic turnUp;
    logic load;
    logic evt;
  } strobeT;

  // Datapath to control counter status
  typedef struct packed {
    logic atLeftEnd;
    logic atTop;
    logic atBottom;
    logic dirUp;
  } statusT;

endpackage

// File: rtl/pwm_chan_ctrl.sv
`timescale 1ns/1ps
module pwm_chan_ctrl
  import pwm_chan_pkg::*;
#(
  parameter int PRE_LOG = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                extTickA,
  input  logic                extTickB,
  input  logic                chanEn,
  input  logic                wrProtect,
  input  logic                modeWr,
  input  logic [MODE_W-1:0]   modeData,
  input  statusT              stat,
  output strobeT              strb,
  output outCfgT              outCfg
);

  localparam logic [3:0] CODE_A = 4'(PRE_LOG + 1);
  localparam logic [3:0] CODE_B = 4'(PRE_LOG + 2);

  modeT               modeQ;
  logic [PRE_LOG-1:0] divCnt;
  logic [PRE_LOG:0]   tap;
  logic               tick;
  logic               tickRun;

  always_ff @(posedge clk) begin
    if (!rstN)                     modeQ <= '0;
    else if (modeWr && !wrProtect) modeQ <= modeT'(modeData);
  end

  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  assign tap[0] = 1'b1;
  for (genvar k = 1; k <= PRE_LOG; k++) begin : g_tap
    assign tap[k] = &divCnt[k-1:0];
  end

  always_comb begin
    tick = 1'b0;
    for (int k = 0; k <= PRE_LOG; k++)
      if (modeQ.prescSel == 4'(k)) tick = tap[k];
    if (modeQ.prescSel == CODE_A) tick = extTickA;
    if (modeQ.prescSel == CODE_B) tick = extTickB;
  end

  assign tickRun = tick && chanEn;

  always_comb begin
    strb          = '0;
    strb.run      = chanEn;
    strb.leftWrap = tickRun && !modeQ.alignCenter && stat.atLeftEnd;
    strb.stepUp   = tickRun && (modeQ.alignCenter ? stat.dirUp : !stat.atLeftEnd);
    strb.stepDown = tickRun && modeQ.alignCenter && !stat.dirUp;
    strb.turnDown = tickRun && modeQ.alignCenter && stat.dirUp && stat.atTop;
    strb.turnUp   = tickRun && modeQ.alignCenter && !stat.dirUp && stat.atBottom;
    strb.load     = !chanEn || strb.leftWrap || strb.turnUp
                    || (strb.turnDown && modeQ.updHalf);
    strb.evt      = strb.leftWrap || strb.turnUp
                    || (strb.turnDown && modeQ.evtHalf);
  end

  assign outCfg = '{startHigh:  modeQ.startHigh,
                    idleInvert: modeQ.idleInvert,
                    compEn:     modeQ.compEn,
                    invHi:      modeQ.invHi,
                    invLo:      modeQ.invLo,
                    trigEvt:    modeQ.trigEvt};

  p_protect_r13: assert property (@(posedge clk) disable iff (!rstN)
    (modeWr && wrProtect) |=> $stable(modeQ));

  p_reserved_still_r10: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ.prescSel > CODE_B) |-> !(strb.stepUp || strb.stepDown || strb.leftWrap));

endmodule

// File: rtl/pwm_chan_dp.sv
`timescale 1ns/1ps
module pwm_chan_dp
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strb,
  input  outCfgT           outCfg,
  input  logic             perWr,
  input  logic [CNT_W-1:0] perData,
  input  logic             dutyWr,
  input  logic [CNT_W-1:0] dutyData,
  output statusT           stat,
  output logic             ocOut,
  output logic             pairHi,
  output logic             pairLo,
  output logic             evtOut,
  output logic             trigOut
);

  logic [CNT_W-1:0] perSh, dutySh, actPer, actDuty, cnt;
  logic             dirUp, evtQ, ocRaw;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perSh  <= '0;
      dutySh <= '0;
    end else begin
      if (perWr)  perSh  <= perData;
      if (dutyWr) dutySh <= dutyData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actPer  <= '0;
      actDuty <= '0;
    end else if (strb.load) begin
      actPer  <= perSh;
      actDuty <= dutySh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strb.run) begin
      cnt   <= '0;
      dirUp <= 1'b1;
    end else begin
      if (strb.leftWrap)      cnt <= '0;
      else if (strb.stepUp)   cnt <= cnt + CNT_W'(1);
      else if (strb.stepDown) cnt <= cnt - CNT_W'(1);
      if (strb.turnDown)      dirUp <= 1'b0;
      else if (strb.turnUp)   dirUp <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) evtQ <= 1'b0;
    else       evtQ <= strb.evt;
  end

  assign stat.atLeftEnd = cnt >= (actPer - CNT_W'(1));
  assign stat.atTop     = ({1'b0, cnt} + 1'b1) >= {1'b0, actPer};
  assign stat.atBottom  = cnt <= CNT_W'(1);
  assign stat.dirUp     = dirUp;

  assign ocRaw   = (cnt < actDuty) ? outCfg.startHigh : !outCfg.startHigh;
  assign ocOut   = strb.run ? ocRaw : (outCfg.startHigh ^ outCfg.idleInvert);
  assign pairHi  = outCfg.compEn ? (ocOut ^ outCfg.invHi) : ocOut;
  assign pairLo  = outCfg.compEn ? (!ocOut ^ outCfg.invLo) : !ocOut;
  assign evtOut  = evtQ;
  assign trigOut = outCfg.trigEvt ? evtQ : ocOut;

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> (cnt == '0 && dirUp));

  p_turn_dir_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && strb.turnDown) |=> !dirUp);

  p_evt_at_turn_r8: assert property (@(posedge clk) disable iff (!rstN)
    evtOut |-> (cnt == '0 || !dirUp));

endmodule

// File: rtl/pwm_chan.sv
`timescale 1ns/1ps
module pwm_chan
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRE_LOG = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extTickA,
  input  logic              extTickB,
  input  logic              chanEn,
  input  logic              wrProtect,
  input  logic              modeWr,
  input  logic [12:0]       modeData,
  input  logic              perWr,
  input  logic [CNT_W-1:0]  perData,
  input  logic              dutyWr,
  input  logic [CNT_W-1:0]  dutyData,
  output logic              ocOut,
  output logic              pairHi,
  output logic              pairLo,
  output logic              evtOut,
  output logic              trigOut
);

  strobeT strb;
  statusT stat;
  outCfgT outCfg;

  pwm_chan_ctrl #(.PRE_LOG(PRE_LOG)) i_ctrl (
    .clk(clk), .rstN(rstN), .extTickA(extTickA), .extTickB(extTickB),
    .chanEn(chanEn), .wrProtect(wrProtect), .modeWr(modeWr),
    .modeData(modeData), .stat(stat), .strb(strb), .outCfg(outCfg)
  );

  pwm_chan_dp #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .outCfg(outCfg),
    .perWr(perWr), .perData(perData), .dutyWr(dutyWr), .dutyData(dutyData),
    .stat(stat), .ocOut(ocOut), .pairHi(pairHi), .pairLo(pairLo),
    .evtOut(evtOut), .trigOut(trigOut)
  );

endmodule

// File: tb/test_pwm_chan.sv
`timescale 1ns/1ps
module test_pwm_chan;

  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extTickA = 1'b0, extTickB = 1'b0, chanEn = 1'b0, wrProtect = 1'b0;
  logic modeWr = 1'b0, perWr = 1'b0, dutyWr = 1'b0;
  logic [12:0] modeData = '0;
  logic [CNT_W-1:0] perData = '0, dutyData = '0;
  logic ocOut, pairHi, pairLo, evtOut, trigOut;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [4:0] v;   // {oc, evt, hi, lo, trig}
    string      tag;
  } itemT;
  itemT expQ[$];

  always #5 clk = ~clk;

  pwm_chan #(.CNT_W(CNT_W), .PRE_LOG(10)) i_pwm_chan (
    .clk(clk), .rstN(rstN), .extTickA(extTickA), .extTickB(extTickB),
    .chanEn(chanEn), .wrProtect(wrProtect), .modeWr(modeWr), .modeData(modeData),
    .perWr(perWr), .perData(perData), .dutyWr(dutyWr), .dutyData(dutyData),
    .ocOut(ocOut), .pairHi(pairHi), .pairLo(pairLo), .evtOut(evtOut), .trigOut(trigOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected sample per cycle
  initial begin
    forever begin
      @(negedge clk); #1;
      if (expQ.size() > 0) begin
        itemT it;
        logic [4:0] act;
        it  = expQ.pop_front();
        act = {ocOut, evtOut, pairHi, pairLo, trigOut};
        checks++;
        if (act !== it.v) begin
          errors++;
          $display("FAIL %s actual=%b expected=%b (oc,evt,hi,lo,trig)", it.tag, act, it.v);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [12:0] mkMode(input bit center, startH, idleInv, updH, evtH,
                                         trigE, compE, invH, invL, input int presc);
    return {invL, invH, compE, trigE, evtH, updH, idleInv, startH, center, 4'(presc)};
  endfunction

  task automatic writeMode(input logic [12:0] m);
    @(negedge clk); modeData = m; modeWr = 1'b1;
    @(negedge clk); modeWr = 1'b0;
  endtask

  task automatic writePerDuty(input int p, input int d);
    @(negedge clk); perData = CNT_W'(p); dutyData = CNT_W'(d); perWr = 1'b1; dutyWr = 1'b1;
    @(negedge clk); perWr = 1'b0; dutyWr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic int cntAt(input bit center, input int p, input int i);
    int c;
    if (!center) return i % p;
    c = i % (2 * p);
    return (c <= p) ? c : 2 * p - c;
  endfunction

  function automatic bit isLoad(input bit center, input bit updH, input int p, input int i);
    if (!center) return (i % p) == 0;
    return ((i % (2 * p)) == 0) || (updH && (i % (2 * p)) == p);
  endfunction

  // Driver: configure, enable, push expected samples, optionally rewrite duty
  task automatic runScen(input bit center, updH, evtH, startH, trigE, compE, invH, invL,
                         input int p, d1, d2, wIdx, n, input string tag);
    int m;
    m = 1 << 30;
    if (wIdx >= 0)
      for (int i = wIdx + 2; i < n + 4 * p; i++)
        if (isLoad(center, updH, p, i)) begin m = i; break; end
    writeMode(mkMode(center, startH, 1'b0, updH, evtH, trigE, compE, invH, invL, 0));
    writePerDuty(p, d1);
    @(negedge clk);
    chanEn = 1'b1;
    for (int i = 0; i < n; i++) begin
      itemT it;
      int c, d;
      bit oc, ev, hi, lo, tr;
      c  = cntAt(center, p, i);
      d  = (i >= m) ? d2 : d1;
      oc = (c < d) ? startH : !startH;
      ev = (i > 0) && (center ? ((i % (2 * p)) == 0 || (evtH && (i % (2 * p)) == p))
                              : ((i % p) == 0));
      hi = compE ? (oc ^ invH) : oc;
      lo = compE ? (!oc ^ invL) : !oc;
      tr = trigE ? ev : oc;
      it.v = {oc, ev, hi, lo, tr};
      it.tag = tag;
      expQ.push_back(it);
    end
    if (wIdx >= 0) begin
      repeat (wIdx) @(negedge clk);
      dutyData = CNT_W'(d2); dutyWr = 1'b1;
      @(negedge clk); dutyWr = 1'b0;
    end
    wait (expQ.size() == 0);
    @(negedge clk); chanEn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int evtSeen, firstIdx, secondIdx;
    logic ocHold;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    chk("R1 oc",   ocOut,   0);
    chk("R1 hi",   pairHi,  0);
    chk("R1 lo",   pairLo,  1);
    chk("R1 trig", trigOut, 0);
    chk("R1 evt",  evtOut,  0);

    // R5: idle level with and without inversion
    writeMode(mkMode(0, 1, 0, 0, 0, 0, 0, 0, 0, 0));
    #1 chk("R5 idle start-high", ocOut, 1);
    writeMode(mkMode(0, 1, 1, 0, 0, 0, 0, 0, 0, 0));
    #1 chk("R5 idle inverted", ocOut, 0);

    // R13: protected write leaves mode (idle level) unchanged
    wrProtect = 1'b1;
    writeMode(mkMode(0, 1, 0, 0, 0, 0, 0, 0, 0, 0));
    #1 chk("R13 protected write ignored", ocOut, 0);
    wrProtect = 1'b0;

    // R2/R8 left, start low
    runScen(0, 0, 0, 0, 0, 0, 0, 0, 5, 2, 2, -1, 20, "R2 left P5 D2");
    // R4 start high, R8 evtHalf ignored in left mode
    runScen(0, 0, 1, 1, 0, 0, 0, 0, 4, 1, 1, -1, 16, "R4 R8 left start-high evtHalf ignored");
    // R3 center
    runScen(1, 0, 0, 0, 0, 0, 0, 0, 4, 2, 2, -1, 24, "R3 center P4 D2");
    // R8 half events, R11 trigger from events
    runScen(1, 0, 1, 0, 1, 0, 0, 0, 4, 1, 1, -1, 24, "R8 R11 center half events");
    // R6 update at period end
    runScen(0, 0, 0, 0, 0, 0, 0, 0, 5, 1, 3, 1, 20, "R6 left update");
    runScen(1, 0, 0, 0, 0, 0, 0, 0, 4, 1, 3, 1, 24, "R6 center full update");
    // R7 update at half period
    runScen(1, 1, 0, 0, 0, 0, 0, 0, 4, 1, 3, 1, 24, "R7 center half update");
    // R12 pair with and without pair enable
    runScen(0, 0, 0, 0, 0, 1, 1, 0, 3, 1, 1, -1, 9, "R12 pair inverted hi");
    runScen(0, 0, 0, 1, 0, 0, 1, 1, 3, 1, 1, -1, 9, "R12 pair enable off");

    // R9: divide-by-4 prescaler, event spacing 4*P
    writeMode(mkMode(0, 0, 0, 0, 0, 0, 0, 0, 0, 2));
    writePerDuty(3, 1);
    @(negedge clk); chanEn = 1'b1;
    firstIdx = -1; secondIdx = -1;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk); #1;
      if (evtOut) begin
        if (firstIdx < 0) firstIdx = i;
        else if (secondIdx < 0) secondIdx = i;
      end
    end
    chk("R9 event spacing /4", secondIdx - firstIdx, 12);
    @(negedge clk); chanEn = 1'b0;

    // R10: clock A ticks only
    writeMode(mkMode(0, 0, 0, 0, 0, 0, 0, 0, 0, 11));
    @(negedge clk); chanEn = 1'b1;
    evtSeen = 0;
    for (int i = 0; i < 6; i++) begin
      extTickB = 1'b1; @(negedge clk); #1; evtSeen += int'(evtOut);
      extTickB = 1'b0; @(negedge clk); #1; evtSeen += int'(evtOut);
    end
    chk("R10 clock B ignored under A select", evtSeen, 0);
    for (int i = 0; i < 3; i++) begin
      extTickA = 1'b1; @(negedge clk); #1; evtSeen += int'(evtOut);
      extTickA = 1'b0; @(negedge clk); #1; evtSeen += int'(evtOut);
    end
    chk("R10 three A ticks make one period", evtSeen, 1);
    @(negedge clk); chanEn = 1'b0;

    // R10: clock B select
    writeMode(mkMode(0, 0, 0, 0, 0, 0, 0, 0, 0, 12));
    @(negedge clk); chanEn = 1'b1;
    evtSeen = 0;
    for (int i = 0; i < 3; i++) begin
      extTickB = 1'b1; @(negedge clk); #1; evtSeen += int'(evtOut);
      extTickB = 1'b0; @(negedge clk); #1; evtSeen += int'(evtOut);
    end
    chk("R10 three B ticks make one period", evtSeen, 1);
    @(negedge clk); chanEn = 1'b0;

    // R10: reserved code never advances
    writeMode(mkMode(0, 0, 0, 0, 0, 0, 0, 0, 0, 13));
    @(negedge clk); chanEn = 1'b1;
    evtSeen = 0;
    ocHold = 1'b0;
    for (int i = 0; i < 40; i++) begin
      extTickA = i[0]; extTickB = i[0];
      @(negedge clk); #1;
      evtSeen += int'(evtOut);
      ocHold |= ocOut;
    end
    extTickA = 1'b0; extTickB = 1'b0;
    chk("R10 reserved code no events", evtSeen, 0);
    chk("R10 reserved code output stays at start", ocHold, 0);
    @(negedge clk); chanEn = 1'b0;

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule